// File: doc/BRIEF.md
# Coherent Two-Way Tag Directory

This block keeps the tags and permission bits of a small private cache and answers one lookup at a time. It has 16 sets of two ways. Each line is 256 bytes, aligned on 256 bytes, and the address is 32 bits wide. A lookup reports whether the line is present. A lookup that misses is given a cause: cold, associativity or communication. The line is then installed, either in an empty way or in place of the least recently used line.

Writes need exclusive permission. A write that misses, or that finds the line present but read-only, is flagged as a write miss. The block then raises an invalidate request toward the other caches and holds it until they acknowledge. After the acknowledge the line is writable, and further writes hit without any new request. Incoming snoop invalidates from other caches remove matching lines. They also leave behind a record, so that a later miss on that line is reported as a communication miss.

The block stores no line data and models no refill timing. Each entry keeps only a valid bit and a writable bit.

Top module: `coh_tag_dir`

## Requirements
- R1: Address bits [11:8] select the set and bits [31:12] form the tag; bits [7:0] play no part. A lookup accepted on one clock edge gives its result on the next cycle only: rsp_valid is high, rsp_hit is 1 when a valid entry of that set holds the tag, and rsp_way names the matching way.
- R2: A miss in a set with a free way installs the line without eviction. It uses way 0 when way 0 is free, otherwise way 1, and rsp_way reports the way used.
- R3: A miss in a set whose two ways are both valid replaces the least recently used way, and rsp_way reports that way. Each hit or install marks the other way as least recently used.
- R4: rsp_miss_type is 00 when the tag is present and 01 for a cold miss. A cold miss is any miss that matches neither record of R5 or R6, which includes every miss after reset.
- R5: rsp_miss_type is 10 when a miss matches the tag most recently evicted from that set.
- R6: rsp_miss_type is 11 when a miss matches the tag most recently removed from that set by a snoop. This check takes precedence over R5.
- R7: rsp_write_miss is 1 for a write that misses, and for a write that hits a read-only line; in the second case rsp_hit stays 1. Reads never set it.
- R8: After a write miss, inv_req rises together with the response, carries the line's tag on inv_tag and its set on inv_set, and stays high and unchanged until inv_ack. While inv_req is high, req_ready is low. After inv_ack the line is writable, so later writes to it report no write miss and raise no request.
- R9: A snoop whose tag matches a valid entry of its set clears that entry's valid and writable bits at the same edge. A snoop that matches nothing changes no entry.
- R10: While snp_valid is high with a snoop address in the same set as req_addr, req_ready is low, so the snoop goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | 1 for a write lookup, 0 for a read |
| req_addr | input | 32 | Lookup byte address |
| req_ready | output | 1 | Lookup accepted when high together with req_valid |
| snp_valid | input | 1 | Incoming invalidate from another cache |
| snp_addr | input | 32 | Byte address of the incoming invalidate |
| inv_req | output | 1 | Request to invalidate other copies before a write |
| inv_tag | output | 20 | Tag of the line being made exclusive |
| inv_set | output | 4 | Set of the line being made exclusive |
| inv_ack | input | 1 | Other caches have dropped their copies |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| rsp_hit | output | 1 | Tag present in the set |
| rsp_miss_type | output | 2 | 00 present, 01 cold, 10 associativity, 11 communication |
| rsp_write_miss | output | 1 | Write needs exclusive permission first |
| rsp_way | output | 1 | Way hit or way installed |

## Verification
Some properties are checked on every cycle by assertions: the invalidate request holds steady until it is acknowledged, lookups are blocked while it is pending and during a same-set snoop, a snoop clears the entry it matches, a present tag always reports code 00, reads never report a write miss, and a fill into a set with way 0 free lands in way 0. Other behaviour depends on history, and only the bench's scenarios can show it. This covers the least-recently-used victim order, the choice between associativity, communication and cold causes, a snoop that matches nothing leaving the lines alone, and writes hitting freely after a granted upgrade. Each of these scenarios is swept over all 16 sets.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [1:0] {
    MK_PRESENT = 2'b00,
    MK_COLD    = 2'b01,
    MK_ASSOC   = 2'b10,
    MK_COMM    = 2'b11
  } miss_kind_e;

  // snoop record takes precedence over eviction record
  function automatic miss_kind_e pick_kind(input logic comm_match, input logic assoc_match);
    if (comm_match)       return MK_COMM;
    else if (assoc_match) return MK_ASSOC;
    else                  return MK_COLD;
  endfunction
endpackage

// File: rtl/tcd_way_match.sv
module tcd_way_match #(
  parameter int TAG_W = 20
) (
  input  logic [1:0]       vld,
  input  logic [TAG_W-1:0] tag0,
  input  logic [TAG_W-1:0] tag1,
  input  logic             lru,
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic             hit_way,
  output logic             victim,
  output logic             full
);
  logic m0, m1;
  assign m0      = vld[0] && (tag0 == key);
  assign m1      = vld[1] && (tag1 == key);
  assign hit     = m0 | m1;
  assign hit_way = m1;
  assign full    = &vld;
  always_comb begin
    if (!vld[0])      victim = 1'b0;
    else if (!vld[1]) victim = 1'b1;
    else              victim = lru;
  end
endmodule

// File: rtl/tcd_miss_class.sv
module tcd_miss_class
  import tcd_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [TAG_W-1:0] key,
  input  logic             ev_vld,
  input  logic [TAG_W-1:0] ev_tag,
  input  logic             sn_vld,
  input  logic [TAG_W-1:0] sn_tag,
  output miss_kind_e       kind
);
  assign kind = pick_kind(sn_vld && (sn_tag == key), ev_vld && (ev_tag == key));
endmodule

// File: rtl/tcd_perm_ctrl.sv
module tcd_perm_ctrl #(
  parameter int TAG_W = 20,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [SET_W-1:0] start_set,
  input  logic             start_way,
  input  logic             inv_ack,
  output logic             inv_req,
  output logic [TAG_W-1:0] inv_tag,
  output logic [SET_W-1:0] inv_set,
  output logic             grant,
  output logic             grant_way
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      inv_tag   <= '0;
      inv_set   <= '0;
      grant_way <= 1'b0;
    end else if (start) begin
      pend_q    <= 1'b1;
      inv_tag   <= start_tag;
      inv_set   <= start_set;
      grant_way <= start_way;
    end else if (pend_q && inv_ack) begin
      pend_q <= 1'b0;
    end
  end

  assign inv_req = pend_q;
  assign grant   = pend_q && inv_ack;

  AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !inv_ack |=> inv_req && $stable(inv_tag) && $stable(inv_set)) // R8
    else $error("inv_req dropped or changed before inv_ack");

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> !start) // R8
    else $error("new upgrade started while one is pending");
endmodule

// File: rtl/coh_tag_dir.sv
module coh_tag_dir
  import tcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8,
  parameter int SET_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  output logic                            req_ready,
  input  logic                            snp_valid,
  input  logic [ADDR_W-1:0]               snp_addr,
  output logic                            inv_req,
  output logic [ADDR_W-OFS_W-SET_W-1:0]   inv_tag,
  output logic [SET_W-1:0]                inv_set,
  input  logic                            inv_ack,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic [1:0]                      rsp_miss_type,
  output logic                            rsp_write_miss,
  output logic                            rsp_way
);
  localparam int TAG_W = ADDR_W - OFS_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic [1:0]       wr_q  [SETS];
  logic             lru_q [SETS];
  logic [TAG_W-1:0] ev_tag_q [SETS];
  logic             ev_vld_q [SETS];
  logic [TAG_W-1:0] sn_tag_q [SETS];
  logic             sn_vld_q [SETS];

  logic unused_ofs;
  assign unused_ofs = ^{req_addr[OFS_W-1:0], snp_addr[OFS_W-1:0]};

  // request side
  logic [SET_W-1:0] r_set;
  logic [TAG_W-1:0] r_tag;
  logic             r_hit, r_hway, r_victim, r_full, r_writable;
  miss_kind_e       r_kind;
  assign r_set = addr_set(req_addr);
  assign r_tag = addr_tag(req_addr);

  tcd_way_match #(.TAG_W(TAG_W)) u_req_match (
    .vld(vld_q[r_set]), .tag0(tag_q[r_set][0]), .tag1(tag_q[r_set][1]),
    .lru(lru_q[r_set]), .key(r_tag),
    .hit(r_hit), .hit_way(r_hway), .victim(r_victim), .full(r_full)
  );

  tcd_miss_class #(.TAG_W(TAG_W)) u_class (
    .key(r_tag), .ev_vld(ev_vld_q[r_set]), .ev_tag(ev_tag_q[r_set]),
    .sn_vld(sn_vld_q[r_set]), .sn_tag(sn_tag_q[r_set]), .kind(r_kind)
  );

  assign r_writable = r_hit && wr_q[r_set][r_hway];

  // snoop side
  logic [SET_W-1:0] s_set;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit, s_way, s_victim_nc, s_full_nc;
  assign s_set = addr_set(snp_addr);
  assign s_tag = addr_tag(snp_addr);

  tcd_way_match #(.TAG_W(TAG_W)) u_snp_match (
    .vld(vld_q[s_set]), .tag0(tag_q[s_set][0]), .tag1(tag_q[s_set][1]),
    .lru(lru_q[s_set]), .key(s_tag),
    .hit(s_hit), .hit_way(s_way), .victim(s_victim_nc), .full(s_full_nc)
  );

  // named internal events
  logic perm_busy, set_clash, req_fire, need_perm, snp_kill, grant, grant_way, chosen_way;
  assign set_clash  = snp_valid && (s_set == r_set);
  assign req_ready  = !perm_busy && !set_clash;
  assign req_fire   = req_valid && req_ready;
  assign need_perm  = req_write && !r_writable;
  assign snp_kill   = snp_valid && s_hit;
  assign chosen_way = r_hit ? r_hway : r_victim;

  tcd_perm_ctrl #(.TAG_W(TAG_W), .SET_W(SET_W)) u_perm (
    .clk(clk), .rst_n(rst_n),
    .start(req_fire && need_perm), .start_tag(r_tag), .start_set(r_set),
    .start_way(chosen_way), .inv_ack(inv_ack),
    .inv_req(inv_req), .inv_tag(inv_tag), .inv_set(inv_set),
    .grant(grant), .grant_way(grant_way)
  );
  assign perm_busy = inv_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s][0] <= '0;
        tag_q[s][1] <= '0;
        vld_q[s]    <= '0;
        wr_q[s]     <= '0;
        lru_q[s]    <= 1'b0;
        ev_tag_q[s] <= '0;
        ev_vld_q[s] <= 1'b0;
        sn_tag_q[s] <= '0;
        sn_vld_q[s] <= 1'b0;
      end
    end else begin
      if (req_fire) begin
        lru_q[r_set] <= ~chosen_way;
        if (!r_hit) begin
          tag_q[r_set][r_victim] <= r_tag;
          vld_q[r_set][r_victim] <= 1'b1;
          wr_q[r_set][r_victim]  <= 1'b0;
          if (r_full) begin
            ev_tag_q[r_set] <= tag_q[r_set][r_victim];
            ev_vld_q[r_set] <= 1'b1;
          end
        end
      end
      if (snp_kill) begin
        vld_q[s_set][s_way] <= 1'b0;
        wr_q[s_set][s_way]  <= 1'b0;
        sn_tag_q[s_set]     <= s_tag;
        sn_vld_q[s_set]     <= 1'b1;
      end
      if (grant) begin
        tag_q[inv_set][grant_way] <= inv_tag;
        vld_q[inv_set][grant_way] <= 1'b1;
        wr_q[inv_set][grant_way]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss_type  <= MK_PRESENT;
      rsp_write_miss <= 1'b0;
      rsp_way        <= 1'b0;
    end else begin
      rsp_valid <= req_fire;
      if (req_fire) begin
        rsp_hit        <= r_hit;
        rsp_miss_type  <= r_hit ? MK_PRESENT : r_kind;
        rsp_write_miss <= need_perm;
        rsp_way        <= chosen_way;
      end
    end
  end

  AST_PRESENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_miss_type == 2'b00) // R4
    else $error("present tag reported with a miss code");

  AST_READ_NO_WMISS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_write |=> !rsp_write_miss) // R7
    else $error("read flagged as write miss");

  AST_FREE_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !r_hit && !vld_q[r_set][0] |=> rsp_way == 1'b0) // R2
    else $error("fill skipped free way 0");

  AST_BLOCK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> !req_ready) // R8
    else $error("lookup accepted during pending upgrade");

  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && addr_set(snp_addr) == addr_set(req_addr) |-> !req_ready) // R10
    else $error("lookup accepted against same-set snoop");

  AST_SNOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill && !(grant && inv_set == s_set && grant_way == s_way)
      |=> !vld_q[$past(s_set)][$past(s_way)]) // R9
    else $error("snooped entry still valid");
endmodule

// File: tb/test_coh_tag_dir.sv
module test_coh_tag_dir;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        inv_req;
  logic [19:0] inv_tag;
  logic [3:0]  inv_set;
  logic        inv_ack = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_write_miss, rsp_way;
  logic [1:0]  rsp_miss_type;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_tag_dir i_coh_tag_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .inv_req(inv_req), .inv_tag(inv_tag), .inv_set(inv_set), .inv_ack(inv_ack),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss_type(rsp_miss_type),
    .rsp_write_miss(rsp_write_miss), .rsp_way(rsp_way)
  );

  // reference state, kept from the requirements
  logic [19:0] m_tag [16][2];
  logic        m_v   [16][2];
  logic        m_w   [16][2];
  logic        m_lru [16];
  logic [19:0] m_ev  [16];
  logic        m_evv [16];
  logic [19:0] m_sn  [16];
  logic        m_snv [16];

  function automatic logic [31:0] mk(input logic [19:0] t, input logic [3:0] s, input logic [7:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(input bit wr, input logic [31:0] a, input string req);
    logic [3:0]  s;
    logic [19:0] t;
    bit h, hw, vic, full, e_wm;
    int e_kind;
    bit cw;
    s = a[11:8];
    t = a[31:12];
    h  = 0; hw = 0;
    if (m_v[s][0] && m_tag[s][0] == t) begin h = 1; hw = 0; end
    if (m_v[s][1] && m_tag[s][1] == t) begin h = 1; hw = 1; end
    full = m_v[s][0] && m_v[s][1];
    vic  = !m_v[s][0] ? 1'b0 : (!m_v[s][1] ? 1'b1 : m_lru[s]);
    if (h) e_kind = 0;
    else if (m_snv[s] && m_sn[s] == t) e_kind = 3;
    else if (m_evv[s] && m_ev[s] == t) e_kind = 2;
    else e_kind = 1;
    e_wm = wr && !(h && m_w[s][hw]);
    cw = h ? hw : vic;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    #1;
    chk(req_ready == 1'b1, req, "ready before lookup", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R1", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_hit == h, req, "rsp_hit", int'(rsp_hit), int'(h));
    chk(int'(rsp_miss_type) == e_kind, req, "rsp_miss_type", int'(rsp_miss_type), e_kind);
    chk(rsp_write_miss == e_wm, req, "rsp_write_miss", int'(rsp_write_miss), int'(e_wm));
    chk(rsp_way == cw, req, "rsp_way", int'(rsp_way), int'(cw));

    m_lru[s] = ~cw;
    if (!h) begin
      if (full) begin m_ev[s] = m_tag[s][vic]; m_evv[s] = 1'b1; end
      m_tag[s][vic] = t; m_v[s][vic] = 1'b1; m_w[s][vic] = 1'b0;
    end

    if (e_wm) begin
      chk(inv_req == 1'b1, "R8", "inv_req raised", int'(inv_req), 1);
      chk(inv_tag == t, "R8", "inv_tag", int'(inv_tag), int'(t));
      chk(inv_set == s, "R8", "inv_set", int'(inv_set), int'(s));
      chk(req_ready == 1'b0, "R8", "ready while pending", int'(req_ready), 0);
      @(negedge clk);
      chk(inv_req == 1'b1 && inv_tag == t, "R8", "inv_req held", int'(inv_req), 1);
      chk(rsp_valid == 1'b0, "R1", "rsp single cycle", int'(rsp_valid), 0);
      inv_ack = 1'b1;
      @(negedge clk);
      inv_ack = 1'b0;
      chk(inv_req == 1'b0, "R8", "inv_req after ack", int'(inv_req), 0);
      m_tag[s][cw] = t; m_v[s][cw] = 1'b1; m_w[s][cw] = 1'b1;
    end else begin
      chk(inv_req == 1'b0, "R8", "no inv_req", int'(inv_req), 0);
    end
  endtask

  task automatic snoop(input logic [31:0] a);
    logic [3:0]  s;
    logic [19:0] t;
    s = a[11:8];
    t = a[31:12];
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    for (int w = 0; w < 2; w++) begin
      if (m_v[s][w] && m_tag[s][w] == t) begin
        m_v[s][w] = 1'b0; m_w[s][w] = 1'b0; m_sn[s] = t; m_snv[s] = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 2; w++) begin
        m_tag[s][w] = '0; m_v[s][w] = 0; m_w[s][w] = 0;
      end
      m_lru[s] = 0; m_ev[s] = '0; m_evv[s] = 0; m_sn[s] = '0; m_snv[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    chk(inv_req == 0, "R8", "reset inv_req", int'(inv_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", int'(req_ready), 1);

    for (int s = 0; s < 16; s++) begin
      logic [19:0] ta, tb, tc, td, te;
      ta = 20'h01000 + 20'(s); tb = 20'h02000 + 20'(s);
      tc = 20'h03000 + 20'(s); td = 20'h04000 + 20'(s); te = 20'h05000 + 20'(s);
      lookup(0, mk(ta, 4'(s), 8'h00), "R4");   // cold after reset, way 0
      lookup(0, mk(ta, 4'(s), 8'hFF), "R1");   // hit, offset ignored
      lookup(0, mk(tb, 4'(s), 8'h3C), "R2");   // fill free way 1
      lookup(0, mk(ta, 4'(s), 8'h11), "R3");   // hit makes way 1 the LRU
      lookup(0, mk(tc, 4'(s), 8'h22), "R3");   // evicts tb from way 1
      lookup(0, mk(tb, 4'(s), 8'h33), "R5");   // associativity miss
      lookup(1, mk(tb, 4'(s), 8'h44), "R7");   // present read-only -> write miss
      lookup(1, mk(tb, 4'(s), 8'h55), "R8");   // now writable
      snoop(mk(td, 4'(s), 8'h00));             // matches nothing
      lookup(0, mk(tc, 4'(s), 8'h66), "R9");   // still a hit
      lookup(0, mk(tb, 4'(s), 8'h77), "R9");   // still a hit
      snoop(mk(tb, 4'(s), 8'h88));             // removes tb
      lookup(0, mk(tb, 4'(s), 8'h99), "R6");   // communication miss into free way
      lookup(0, mk(ta, 4'(s), 8'hAA), "R5");   // ta was evicted earlier
      lookup(1, mk(te, 4'(s), 8'hBB), "R7");   // cold write miss
      lookup(1, mk(te, 4'(s), 8'hCC), "R8");   // hits writable
    end

    // snoop and lookup on the same set in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = mk(20'h05003, 4'd3, 8'h00);
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(20'h05003, 4'd3, 8'h10);
    #1;
    chk(req_ready == 0, "R10", "ready during same-set snoop", int'(req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0; req_valid = 1'b0;
    chk(rsp_valid == 0, "R10", "no response while blocked", int'(rsp_valid), 0);
    m_v[3][0] = m_v[3][0]; // model updated below
    for (int w = 0; w < 2; w++)
      if (m_v[3][w] && m_tag[3][w] == 20'h05003) begin
        m_v[3][w] = 0; m_w[3][w] = 0; m_sn[3] = 20'h05003; m_snv[3] = 1;
      end
    lookup(0, mk(20'h05003, 4'd3, 8'h10), "R6");

    // different-set snoop does not block
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = mk(20'h0ABCD, 4'd7, 8'h00);
    req_addr = mk(20'h01002, 4'd2, 8'h00);
    #1;
    chk(req_ready == 1, "R10", "ready with other-set snoop", int'(req_ready), 1);
    @(negedge clk);
    snp_valid = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule